// File: doc/BRIEF.md
# Serial configuration bitstream sequencer

This block is the digital core of a serial memory that feeds a stored configuration bitstream to an FPGA, one bit per serial clock. The bitstream sits in a small byte-wide store that is filled through a parallel write port. A select input gates the stream. An enable/reset pin, whose active level is chosen by a polarity input, either restarts the stream or lets it run. While it streams, the block drives the serial data pin through a separate drive enable.

The block takes one of two roles, fixed each time it leaves reset. As chain master it makes the serial clock by dividing the system clock. As a downstream device it follows a serial clock from outside. When every stored bit has been sent, it pulls a chain-select output low to wake the next memory and stops driving data. A master then gives sixteen trailing clocks after the FPGA releases the select, and then parks the clock low. An open-drain ready output is held low while the power-on cycle runs. A sticky error flag reports a select that was dropped early or held too long after the end.

Top module: `cfg_stream_seq`

## Requirements
- R1: While the block is in effective reset (enable pin at its reset level, or power-on cycle running), the bit address returns to zero and `sdat_drive` is 0, whatever the level of `sel_n`.
- R2: The bit address advances by one on each serial clock rising edge while the block is enabled, `sel_n` is 0 and not all TOTAL_BITS bits are sent. Bit number i is bit (i mod 8) of stored byte i/8, so each byte is sent least-significant bit first, and `sdat_out` shows bit i until the edge that advances past it.
- R3: While `sel_n` is 1, the address is frozen, `sdat_drive` is 0 and a master's clock stops. When `sel_n` returns to 0, the stream resumes at the same bit.
- R4: The level of `sel_n` during effective reset sets the role once reset ends. Low gives master (`sclk_drive`=1, clock from the divider). High gives downstream (`sclk_drive`=0, rising edges of `sclk_in` are counted).
- R5: Once TOTAL_BITS bits are sent, `chain_sel_n` goes to 0 and `sdat_drive` stays 0. Further clock edges change neither.
- R6: A master that has sent every bit keeps clocking while `sel_n` is 0. After `sel_n` rises, it gives exactly TRAIL more rising edges and then holds `sclk_out` at 0.
- R7: The master clock period is 2*DIV system clocks. The master clock is 0 during effective reset.
- R8: `en_pol`=1 makes `en_pin`=1 enable and `en_pin`=0 reset. `en_pol`=0 reverses both levels.
- R9: `rdy_pull` is 1 while `rst_n` is low and for POR_CYCLES clocks after its release, then 0.
- R10: For a master, `cfg_err` is set if `sel_n` rises before the last bit, or if `sel_n` stays 0 for ERR_WAIT clocks after the last bit. Effective reset clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| wr_en | input | 1 | Store write strobe |
| wr_addr | input | WAW | Byte address of the write |
| wr_data | input | 8 | Byte to store |
| en_pol | input | 1 | Polarity of the enable/reset pin (1: high enables) |
| en_pin | input | 1 | Enable/reset pin |
| sel_n | input | 1 | Device select, active low |
| sclk_in | input | 1 | Serial clock from upstream (downstream role) |
| sclk_out | output | 1 | Generated serial clock (master role) |
| sclk_drive | output | 1 | 1 when this block drives the serial clock |
| sdat_out | output | 1 | Serial data value |
| sdat_drive | output | 1 | Drive enable for serial data |
| chain_sel_n | output | 1 | Low once all bits are sent; selects the next device |
| rdy_pull | output | 1 | Open-drain ready pull-down, 1 during power-on |
| cfg_err | output | 1 | Sticky configuration error flag |

## Verification
The trailing-clock phase is the state that is hardest to reach. It exists only for a master that has sent every bit and then sees its select rise. To get there, the bench runs a whole stream in master role and tracks each rising edge of the generated clock. It raises the select on the cycle after `chain_sel_n` falls, then counts every later clock edge over a window well past TRAIL. The two error paths are reached the same way: one pauses a stream partway and the other holds the select low past the end. A resume after the pause shows that no bit was skipped.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;

  // Resolve the enable/reset pin against its programmed polarity.
  function automatic logic eff_enable(input logic pol_hi, input logic pin);
    return pol_hi ? pin : ~pin;
  endfunction

  // Select one bit of a stored byte (least-significant first order).
  function automatic logic pick_bit(input logic [7:0] byte_v, input logic [2:0] idx);
    return byte_v[idx];
  endfunction

endpackage

// File: rtl/cfg_por_timer.sv
module cfg_por_timer #(
  parameter int POR_CYCLES = 8,
  localparam int PW = (POR_CYCLES > 1) ? $clog2(POR_CYCLES + 1) : 1
) (
  input  logic clk,
  input  logic rst_n,
  output logic busy
);
  logic [PW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       cnt <= '0;
    else if (cnt != PW'(POR_CYCLES))  cnt <= cnt + 1'b1;
  end

  assign busy = (cnt != PW'(POR_CYCLES));
endmodule

// File: rtl/cfg_sclk_gen.sv
module cfg_sclk_gen #(
  parameter int DIV = 2,
  localparam int DCW = (DIV > 1) ? $clog2(DIV) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_rst,
  input  logic run_req,
  output logic sclk,
  output logic rise
);
  logic [DCW-1:0] cnt;
  logic           at_end;

  assign at_end = (cnt == DCW'(DIV - 1));
  assign rise   = !in_rst && run_req && !sclk && at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      sclk <= 1'b0;
    end else if (in_rst) begin
      cnt  <= '0;
      sclk <= 1'b0;
    end else if (run_req || sclk) begin
      if (at_end) begin
        cnt  <= '0;
        sclk <= ~sclk;
      end else begin
        cnt  <= cnt + 1'b1;
      end
    end else begin
      cnt <= '0;
    end
  end
endmodule

// File: rtl/cfg_bit_store.sv
module cfg_bit_store #(
  parameter int TOTAL_BITS = 100,
  localparam int MEM_BYTES = (TOTAL_BITS + 7) / 8,
  localparam int WAW = (MEM_BYTES > 1) ? $clog2(MEM_BYTES) : 1,
  localparam int BW = $clog2(TOTAL_BITS + 1)
) (
  input  logic           clk,
  input  logic           wr_en,
  input  logic [WAW-1:0] wr_addr,
  input  logic [7:0]     wr_data,
  input  logic [BW-1:0]  rd_idx,
  output logic           rd_bit
);
  import cfg_seq_pkg::*;

  logic [7:0] mem [MEM_BYTES];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign rd_bit = pick_bit(mem[WAW'(rd_idx >> 3)], rd_idx[2:0]);
endmodule

// File: rtl/cfg_stream_seq.sv
module cfg_stream_seq #(
  parameter int TOTAL_BITS = 100,
  parameter int DIV        = 2,
  parameter int TRAIL      = 16,
  parameter int ERR_WAIT   = 64,
  parameter int POR_CYCLES = 8,
  localparam int MEM_BYTES = (TOTAL_BITS + 7) / 8,
  localparam int WAW = (MEM_BYTES > 1) ? $clog2(MEM_BYTES) : 1,
  localparam int BW  = $clog2(TOTAL_BITS + 1),
  localparam int TW  = $clog2(TRAIL + 1),
  localparam int EW  = $clog2(ERR_WAIT + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [WAW-1:0] wr_addr,
  input  logic [7:0]     wr_data,
  input  logic           en_pol,
  input  logic           en_pin,
  input  logic           sel_n,
  input  logic           sclk_in,
  output logic           sclk_out,
  output logic           sclk_drive,
  output logic           sdat_out,
  output logic           sdat_drive,
  output logic           chain_sel_n,
  output logic           rdy_pull,
  output logic           cfg_err
);
  import cfg_seq_pkg::*;

  // Named internal events, also used by the bound checker.
  logic          por_busy;
  logic          in_rst;
  logic          is_master;
  logic [BW-1:0] addr;
  logic          all_sent;
  logic          m_sclk, m_rise;
  logic          sclk_q, s_rise, rise;
  logic          adv;
  logic [TW-1:0] trail_cnt;
  logic          trail_left;
  logic          run_req;
  logic          sel_q;
  logic [EW-1:0] wait_cnt;
  logic          stored_bit;

  cfg_por_timer #(.POR_CYCLES(POR_CYCLES)) u_por (
    .clk(clk), .rst_n(rst_n), .busy(por_busy)
  );

  assign in_rst     = por_busy | ~eff_enable(en_pol, en_pin);
  assign all_sent   = (addr == BW'(TOTAL_BITS));
  assign trail_left = (trail_cnt != TW'(TRAIL));
  assign run_req    = is_master & (~sel_n | (all_sent & trail_left));

  cfg_sclk_gen #(.DIV(DIV)) u_clkgen (
    .clk(clk), .rst_n(rst_n), .in_rst(in_rst), .run_req(run_req),
    .sclk(m_sclk), .rise(m_rise)
  );

  assign s_rise = sclk_in & ~sclk_q;
  assign rise   = is_master ? m_rise : s_rise;
  assign adv    = rise & ~in_rst & ~sel_n & ~all_sent;

  cfg_bit_store #(.TOTAL_BITS(TOTAL_BITS)) u_store (
    .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_idx(addr), .rd_bit(stored_bit)
  );

  // Edge trackers for the external clock and the select.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      sel_q  <= 1'b1;
    end else begin
      sclk_q <= sclk_in;
      sel_q  <= sel_n;
    end
  end

  // Role latch: follows the select while in reset, frozen afterwards.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      is_master <= 1'b0;
    else if (in_rst) is_master <= ~sel_n;
  end

  // Bit address counter.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      addr <= '0;
    else if (in_rst) addr <= '0;
    else if (adv)    addr <= addr + 1'b1;
  end

  // Trailing clock counter for the master after release of the select.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      trail_cnt <= '0;
    else if (in_rst) trail_cnt <= '0;
    else if (is_master && all_sent && sel_n && rise && trail_left)
                     trail_cnt <= trail_cnt + 1'b1;
  end

  // Configuration error detection (master only).
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_err  <= 1'b0;
      wait_cnt <= '0;
    end else if (in_rst) begin
      cfg_err  <= 1'b0;
      wait_cnt <= '0;
    end else begin
      if (is_master && sel_n && !sel_q && !all_sent) cfg_err <= 1'b1;
      if (is_master && all_sent && !sel_n) begin
        if (wait_cnt == EW'(ERR_WAIT)) cfg_err  <= 1'b1;
        else                           wait_cnt <= wait_cnt + 1'b1;
      end
    end
  end

  assign sclk_out    = m_sclk;
  assign sclk_drive  = is_master;
  assign sdat_out    = stored_bit;
  assign sdat_drive  = ~in_rst & ~sel_n & ~all_sent;
  assign chain_sel_n = ~all_sent;
  assign rdy_pull    = por_busy;
endmodule

// File: rtl/cfg_stream_seq_chk.sv
module cfg_stream_seq_chk #(
  parameter int TOTAL_BITS = 100,
  parameter int TRAIL      = 16,
  parameter int BW         = 7,
  parameter int TW         = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_rst,
  input logic          is_master,
  input logic          sel_n,
  input logic [BW-1:0] addr,
  input logic          sdat_drive,
  input logic          chain_sel_n,
  input logic          sclk_out,
  input logic [TW-1:0] trail_cnt
);
  AST_RESET_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    in_rst |=> (addr == '0)); // R1

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !in_rst |=> (addr == $past(addr) || {1'b0, addr} == {1'b0, $past(addr)} + 1'b1)); // R2

  AST_STANDBY_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_n && !in_rst) |=> $stable(addr)); // R3

  AST_ROLE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_rst |=> $stable(is_master)); // R4

  AST_CHAIN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !chain_sel_n |-> !sdat_drive); // R5

  AST_TRAIL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    trail_cnt <= TW'(TRAIL)); // R6

  AST_CLK_LOW_IN_RST: assert property (@(posedge clk) disable iff (!rst_n)
    in_rst |=> !sclk_out); // R7

  AST_ADDR_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    addr <= BW'(TOTAL_BITS)); // R5
endmodule

bind cfg_stream_seq cfg_stream_seq_chk #(
  .TOTAL_BITS(TOTAL_BITS), .TRAIL(TRAIL), .BW(BW), .TW(TW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_rst(in_rst), .is_master(is_master),
  .sel_n(sel_n), .addr(addr), .sdat_drive(sdat_drive),
  .chain_sel_n(chain_sel_n), .sclk_out(sclk_out), .trail_cnt(trail_cnt)
);

// File: tb/cfg_stream_seq_tb.sv
`timescale 1ns/1ps
module cfg_stream_seq_tb;
  localparam int TOTAL = 100;
  localparam int DIV   = 2;
  localparam int TRAIL = 16;
  localparam int EWAIT = 64;
  localparam int PORC  = 8;
  localparam int NBYTE = (TOTAL + 7) / 8;
  localparam int WAW   = $clog2(NBYTE);

  logic clk = 0;
  always #5 clk = ~clk;

  logic rst_n = 0, wr_en = 0, en_pol = 1, en_pin = 0, sel_n = 0, sclk_in = 0;
  logic [WAW-1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic sclk_out, sclk_drive, sdat_out, sdat_drive, chain_sel_n, rdy_pull, cfg_err;

  cfg_stream_seq #(.TOTAL_BITS(TOTAL), .DIV(DIV), .TRAIL(TRAIL),
                   .ERR_WAIT(EWAIT), .POR_CYCLES(PORC)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .en_pol(en_pol), .en_pin(en_pin), .sel_n(sel_n), .sclk_in(sclk_in),
    .sclk_out(sclk_out), .sclk_drive(sclk_drive), .sdat_out(sdat_out),
    .sdat_drive(sdat_drive), .chain_sel_n(chain_sel_n), .rdy_pull(rdy_pull),
    .cfg_err(cfg_err)
  );

  int total = 0, bad = 0, cyc = 0;
  bit finished = 0;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] pat_byte(input int i);
    return 8'((i * 37 + 5) ^ 8'hA5);
  endfunction
  function automatic logic exp_bit(input int i);
    logic [7:0] b;
    b = pat_byte(i / 8);
    return b[i % 8];
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Put the block in effective reset with the given select, then release.
  task automatic pin_reset(input logic sel);
    @(negedge clk);
    en_pin = ~en_pol; sel_n = sel;
    repeat (3) @(negedge clk);
    en_pin = en_pol;
  endtask

  // Follow the master clock; compare each bit seen at a rising edge.
  task automatic run_master(input int start, input int n, output int got,
                            output int errs, output int period);
    logic prev, last, last_oe;
    int t0;
    got = 0; errs = 0; period = 0; t0 = -1;
    prev = sclk_out; last = sdat_out; last_oe = sdat_drive;
    for (int k = 0; k < n * 4 * DIV + 40; k++) begin
      @(negedge clk);
      if (sclk_out && !prev) begin
        if (last !== exp_bit(start + got) || !last_oe) errs++;
        got++;
        if (t0 < 0) t0 = cyc; else if (period == 0) period = cyc - t0;
      end
      prev = sclk_out;
      if (!sclk_out) begin last = sdat_out; last_oe = sdat_drive; end
      if (got == n || !chain_sel_n) break;
    end
  endtask

  task automatic count_rises(input int win, output int n);
    logic prev;
    n = 0; prev = sclk_out;
    for (int k = 0; k < win; k++) begin
      @(negedge clk);
      if (sclk_out && !prev) n++;
      prev = sclk_out;
    end
  endtask

  task automatic slave_pulse();
    @(negedge clk) sclk_in = 1;
    @(negedge clk) sclk_in = 0;
    @(negedge clk);
  endtask

  // {en_pol, en_pin, sel_n, expected sdat_drive}
  localparam logic [3:0] VEC [0:7] = '{
    4'b1101, 4'b1000, 4'b1110, 4'b1010,
    4'b0001, 4'b0100, 4'b0010, 4'b0110 };

  initial begin
    int got, errs, per, n;
    // R9: reset state
    repeat (3) @(negedge clk);
    chk(rdy_pull == 1, "R9 pull during rst_n", rdy_pull, 1);
    chk(sdat_drive == 0, "R1 no drive in reset", sdat_drive, 0);
    chk(chain_sel_n == 1, "R5 chain high in reset", chain_sel_n, 1);
    for (int i = 0; i < NBYTE; i++) begin
      wr_en = 1; wr_addr = WAW'(i); wr_data = pat_byte(i);
      @(negedge clk);
    end
    wr_en = 0;
    rst_n = 1;
    @(negedge clk);
    chk(rdy_pull == 1, "R9 pull during power-on cycle", rdy_pull, 1);
    chk(sdat_drive == 0, "R1 no drive during power-on", sdat_drive, 0);
    repeat (PORC + 2) @(negedge clk);
    chk(rdy_pull == 0, "R9 released", rdy_pull, 0);

    // R8 / R1 / R3: polarity and select table
    foreach (VEC[i]) begin
      en_pol = VEC[i][3]; en_pin = VEC[i][2]; sel_n = VEC[i][1];
      repeat (2) @(negedge clk);
      chk(sdat_drive == VEC[i][0], $sformatf("R8 vector %0d drive", i), sdat_drive, VEC[i][0]);
    end

    // Master full stream: R4 R2 R7 R5 R6
    en_pol = 1;
    pin_reset(1'b0);
    run_master(0, TOTAL, got, errs, per);
    chk(sclk_drive == 1, "R4 master drives clock", sclk_drive, 1);
    chk(got == TOTAL, "R5 bit count before chain select", got, TOTAL);
    chk(errs == 0, "R2 master bit values LSB first", errs, 0);
    chk(per == 2 * DIV, "R7 clock period", per, 2 * DIV);
    chk(chain_sel_n == 0, "R5 chain select low at end", chain_sel_n, 0);
    chk(sdat_drive == 0, "R5 data released at end", sdat_drive, 0);
    sel_n = 1;
    count_rises(TRAIL * 2 * DIV * 3, n);
    chk(n == TRAIL, "R6 trailing edges", n, TRAIL);
    chk(sclk_out == 0, "R6 clock parked low", sclk_out, 0);
    chk(cfg_err == 0, "R10 no error on clean finish", cfg_err, 0);
    chk(chain_sel_n == 0, "R5 chain stays low", chain_sel_n, 0);

    // Early select release: R10 R3
    pin_reset(1'b0);
    run_master(0, 20, got, errs, per);
    sel_n = 1;
    repeat (3) @(negedge clk);
    chk(cfg_err == 1, "R10 early release flagged", cfg_err, 1);
    chk(sdat_drive == 0, "R3 no drive in standby", sdat_drive, 0);
    count_rises(30, n);
    chk(n == 0, "R3 master clock stopped in standby", n, 0);
    sel_n = 0;
    run_master(20, 10, got, errs, per);
    chk(errs == 0 && got == 10, "R3 resume at same bit", errs, 0);

    // Mid-stream pin reset: R1 R7
    @(negedge clk) en_pin = 0;
    repeat (2) @(negedge clk);
    chk(sdat_drive == 0, "R1 reset releases data", sdat_drive, 0);
    chk(sclk_out == 0, "R7 clock low in reset", sclk_out, 0);
    chk(cfg_err == 0, "R10 reset clears error", cfg_err, 0);
    en_pin = 1;
    run_master(0, 8, got, errs, per);
    chk(errs == 0 && got == 8, "R1 restart from bit 0", errs, 0);

    // Select held low after end: R10
    run_master(8, TOTAL - 8, got, errs, per);
    chk(cfg_err == 0, "R10 no error right at end", cfg_err, 0);
    repeat (EWAIT + 10) @(negedge clk);
    chk(cfg_err == 1, "R10 held-low select flagged", cfg_err, 1);

    // Downstream role: R4 R3 R2 R5
    pin_reset(1'b1);
    @(negedge clk);
    chk(sclk_drive == 0, "R4 downstream does not drive clock", sclk_drive, 0);
    repeat (3) slave_pulse();
    sel_n = 0;
    @(negedge clk);
    chk(sdat_drive == 1 && sdat_out == exp_bit(0), "R3 edges ignored while deselected",
        sdat_out, exp_bit(0));
    errs = 0;
    for (int i = 0; i < TOTAL; i++) begin
      if (sdat_out !== exp_bit(i) || !sdat_drive) errs++;
      slave_pulse();
    end
    chk(errs == 0, "R2 downstream bit values", errs, 0);
    chk(chain_sel_n == 0, "R5 downstream chain select", chain_sel_n, 0);
    repeat (3) slave_pulse();
    chk(chain_sel_n == 0 && sdat_drive == 0, "R5 extra edges no effect", sdat_drive, 0);
    chk(cfg_err == 0, "R10 downstream never flags", cfg_err, 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule